// File: doc/BRIEF.md
# Multi-Stream Slot Pacing Calculator

This block works out the two pacing numbers that let one video stream share the time slots of a multi-stream transport link. From the stream's pixel clock, bits per pixel, payload bandwidth number, the link rate and the number of lanes, it forms a slot target. That target is the mean of a lower bound, set by the pixel data rate, and an upper bound, set by the bandwidth allocation. Optional compression and forward-error-correction overhead multipliers are then applied to the target. It outputs an integer symbol count per slot and a fractional part in 1/256 steps.

A one-cycle `start` pulse captures every input, and the calculation then runs on one shared iterative divider and one shared iterative multiplier. Every intermediate value is an unsigned fixed-point number with 32 integer and 32 fraction bits. A one-cycle `done` pulse ends the calculation. The results stay on the outputs until the next calculation finishes. If the link rate or the lane count is zero, the block raises an error flag and returns zeros.

Top module: `slot_pace_calc`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `x_int` and `y_frac` are all 0.
- R2: The lower bound is floor(2^32·pclk·b·8 / (lclk·lanes)) in 32.32 format. Here b is `comp_bpp` when `comp_en` is 1 and `bpp` when it is 0.
- R3: The upper bound is floor(2^32·pbn·54000 / (lclk·lanes)). The raw target is floor((lower + upper)/2).
- R4: A non-zero `dsc_fp` multiplies the raw target first, then a non-zero `fec_fp` multiplies it. Each product keeps bits [95:32] of the full product. A factor equal to 0 is skipped and leaves the target unchanged.
- R5: The fraction numerator is floor(frac(target)·256·lanes) when the target has a non-zero fraction. It is 256·lanes when the target is an exact integer, so an exact target T gives `x_int` = T+1 and `y_frac` = 0 at one lane.
- R6: The symbol count S = (int(target)·2^32 + floor(2^32·numerator/(256·lanes)))·lanes, kept to 64 bits. `x_int` is S[63:32]. `y_frac` is ceil(S[31:0]·256 / 2^32) and lies in 0..256.
- R7: When `lclk` or `lanes` is 0 at `start`, the next `done` comes with `err` = 1 and with `x_int` = `y_frac` = 0. A valid calculation clears `err`.
- R8: `done` is high for exactly one cycle and never together with `busy`. `busy` is high from the cycle after an accepted `start` until `done`. `x_int`, `y_frac` and `err` change only in the cycle in which `done` is high.
- R9: A `start` while `busy` is high is ignored. The running calculation finishes with the inputs captured at its own `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture inputs and begin a calculation |
| pclk_khz | input | PCLK_W | Pixel clock in kHz |
| bpp | input | BPP_W | Uncompressed bits per pixel |
| comp_en | input | 1 | Compression active, use `comp_bpp` |
| comp_bpp | input | BPP_W | Compressed bits per pixel |
| pbn | input | PBN_W | Payload bandwidth number |
| lclk | input | LCLK_W | Link rate |
| lanes | input | LANE_W | Lane count |
| dsc_fp | input | 64 | Compression overhead factor, 32.32, 0 = none |
| fec_fp | input | 64 | FEC overhead factor, 32.32, 0 = none |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last calculation had a zero divisor |
| x_int | output | 32 | Integer symbols per slot |
| y_frac | output | 9 | Fraction numerator in 1/256 steps |

## Verification
The path that is hardest to reach from the ports is the exact-integer target. There the fraction numerator falls back to 256·lanes and the integer count is carried up by one (R5). The stimulus reaches it with a vector whose lower and upper bounds are both whole numbers with a whole mean (64 and 108 slots at one lane, so the expected result is 87 and 0). A second hard case is a start pulse with different inputs in the middle of a calculation (R9), which is checked against the result for the first inputs.

// File: rtl/slot_pace_pkg.sv
package slot_pace_pkg;
   localparam int QW   = 64;
   localparam int FRAC = 32;

   typedef enum logic [3:0] {
      ST_IDLE, ST_DMIN, ST_DMAX, ST_MDSC, ST_MFEC,
      ST_PREP, ST_MEN, ST_DFR, ST_MLN, ST_FIN
   } pace_st_t;
endpackage

// File: rtl/slot_pace_div.sv
module slot_pace_div #(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic [W-1:0] quo,
   output logic         done
);
   localparam int CW = $clog2(W + 1);

   if (W < 2) begin : g_bad_w
      $error("slot_pace_div: W must be at least 2");
   end

   logic [W-1:0]  q_r, r_r, d_r;
   logic [CW-1:0] cnt;
   logic          run;
   logic [W:0]    sh, diff;
   logic          fits;

   assign sh   = {r_r, q_r[W-1]};
   assign diff = sh - {1'b0, d_r};
   assign fits = sh >= {1'b0, d_r};
   assign quo  = q_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_r  <= '0;
         r_r  <= '0;
         d_r  <= '0;
         cnt  <= '0;
         run  <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            q_r <= num;
            r_r <= '0;
            d_r <= den;
            cnt <= CW'(W);
            run <= 1'b1;
         end else if (run) begin
            r_r <= fits ? diff[W-1:0] : sh[W-1:0];
            q_r <= {q_r[W-2:0], fits};
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1)) begin
               run  <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/slot_pace_mul.sv
module slot_pace_mul #(
   parameter int W    = 64,
   parameter bit FAST = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [2*W-1:0] prod,
   output logic           done
);
   localparam int STEP = FAST ? 2 : 1;
   localparam int ITER = W / STEP;
   localparam int CW   = $clog2(ITER + 1);

   if (W % 2 != 0) begin : g_bad_w
      $error("slot_pace_mul: W must be even");
   end

   logic [2*W-1:0] acc, mc, addend;
   logic [W-1:0]   mp;
   logic [CW-1:0]  cnt;
   logic           run;

   if (FAST) begin : g_radix4
      assign addend = (mp[0] ? mc : '0) + (mp[1] ? {mc[2*W-2:0], 1'b0} : '0);
   end else begin : g_radix2
      assign addend = mp[0] ? mc : '0;
   end

   assign prod = acc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc  <= '0;
         mc   <= '0;
         mp   <= '0;
         cnt  <= '0;
         run  <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            acc <= '0;
            mc  <= {{W{1'b0}}, a};
            mp  <= b;
            cnt <= CW'(ITER);
            run <= 1'b1;
         end else if (run) begin
            acc <= acc + addend;
            mc  <= mc << STEP;
            mp  <= mp >> STEP;
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1)) begin
               run  <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/slot_pace_calc.sv
module slot_pace_calc
   import slot_pace_pkg::*;
#(
   parameter int PCLK_W   = 20,
   parameter int BPP_W    = 8,
   parameter int PBN_W    = 15,
   parameter int LCLK_W   = 20,
   parameter int LANE_W   = 3,
   parameter bit FAST_MUL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [PCLK_W-1:0] pclk_khz,
   input  logic [BPP_W-1:0]  bpp,
   input  logic              comp_en,
   input  logic [BPP_W-1:0]  comp_bpp,
   input  logic [PBN_W-1:0]  pbn,
   input  logic [LCLK_W-1:0] lclk,
   input  logic [LANE_W-1:0] lanes,
   input  logic [63:0]       dsc_fp,
   input  logic [63:0]       fec_fp,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [31:0]       x_int,
   output logic [8:0]        y_frac
);
   localparam int EN_W = LANE_W + 8;
   localparam int Y_W  = 9;

   if (PCLK_W + BPP_W + 3 > FRAC) begin : g_bad_pix
      $error("slot_pace_calc: pixel rate product exceeds integer range");
   end
   if (PBN_W + 16 > FRAC) begin : g_bad_pbn
      $error("slot_pace_calc: bandwidth product exceeds integer range");
   end
   if (LCLK_W + LANE_W > QW) begin : g_bad_den
      $error("slot_pace_calc: divisor too wide");
   end

   pace_st_t          st;
   logic              kick;
   logic [PCLK_W-1:0] pclk_r;
   logic [BPP_W-1:0]  bpp_r;
   logic [PBN_W-1:0]  pbn_r;
   logic [LCLK_W-1:0] lclk_r;
   logic [LANE_W-1:0] lanes_r;
   logic [QW-1:0]     dsc_r, fec_r;
   logic [QW-1:0]     minq, raw, tss;
   logic [EN_W-1:0]   enum_r;
   logic [EN_W-1:0]   lane_scale;

   logic [QW-1:0]     div_num, div_den, div_quo;
   logic              div_done, div_start;
   logic [QW-1:0]     mul_a, mul_b;
   logic [2*QW-1:0]   mul_prod;
   logic              mul_done, mul_start;
   logic [QW:0]       bound_sum;

   assign lane_scale = {lanes_r, 8'd0};
   assign bound_sum  = {1'b0, minq} + {1'b0, div_quo};
   assign div_start  = kick && (st == ST_DMIN || st == ST_DMAX || st == ST_DFR);
   assign mul_start  = kick && (st == ST_MDSC || st == ST_MFEC ||
                                st == ST_MEN  || st == ST_MLN);

   always_comb begin
      div_num = '0;
      div_den = QW'(lclk_r) * QW'(lanes_r);
      case (st)
         ST_DMIN: div_num = (QW'(pclk_r) * QW'(bpp_r) * QW'(8)) << FRAC;
         ST_DMAX: div_num = (QW'(pbn_r) * QW'(54000)) << FRAC;
         ST_DFR: begin
            div_num = QW'(enum_r) << FRAC;
            div_den = QW'(lane_scale);
         end
         default: ;
      endcase
   end

   always_comb begin
      mul_a = raw;
      mul_b = '0;
      case (st)
         ST_MDSC: mul_b = dsc_r;
         ST_MFEC: mul_b = fec_r;
         ST_MEN: begin
            mul_a = {{(QW-FRAC){1'b0}}, raw[FRAC-1:0]};
            mul_b = QW'(lane_scale);
         end
         ST_MLN: begin
            mul_a = tss;
            mul_b = QW'(lanes_r);
         end
         default: ;
      endcase
   end

   slot_pace_div #(.W(QW)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (div_start),
      .num   (div_num),
      .den   (div_den),
      .quo   (div_quo),
      .done  (div_done)
   );

   slot_pace_mul #(.W(QW), .FAST(FAST_MUL)) u_mul (
      .clk   (clk),
      .rst_n (rst_n),
      .start (mul_start),
      .a     (mul_a),
      .b     (mul_b),
      .prod  (mul_prod),
      .done  (mul_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         kick    <= 1'b0;
         pclk_r  <= '0;
         bpp_r   <= '0;
         pbn_r   <= '0;
         lclk_r  <= '0;
         lanes_r <= '0;
         dsc_r   <= '0;
         fec_r   <= '0;
         minq    <= '0;
         raw     <= '0;
         tss     <= '0;
         enum_r  <= '0;
         busy    <= 1'b0;
         done    <= 1'b0;
         err     <= 1'b0;
         x_int   <= '0;
         y_frac  <= '0;
      end else begin
         kick <= 1'b0;
         done <= 1'b0;
         case (st)
            ST_IDLE: if (start) begin
               pclk_r  <= pclk_khz;
               bpp_r   <= comp_en ? comp_bpp : bpp;
               pbn_r   <= pbn;
               lclk_r  <= lclk;
               lanes_r <= lanes;
               dsc_r   <= dsc_fp;
               fec_r   <= fec_fp;
               if (lclk == '0 || lanes == '0) begin
                  err    <= 1'b1;
                  x_int  <= '0;
                  y_frac <= '0;
                  done   <= 1'b1;
               end else begin
                  busy <= 1'b1;
                  st   <= ST_DMIN;
                  kick <= 1'b1;
               end
            end
            ST_DMIN: if (div_done) begin
               minq <= div_quo;
               st   <= ST_DMAX;
               kick <= 1'b1;
            end
            ST_DMAX: if (div_done) begin
               raw <= bound_sum[QW:1];
               if (dsc_r != '0) begin
                  st <= ST_MDSC; kick <= 1'b1;
               end else if (fec_r != '0) begin
                  st <= ST_MFEC; kick <= 1'b1;
               end else begin
                  st <= ST_PREP;
               end
            end
            ST_MDSC: if (mul_done) begin
               raw <= mul_prod[QW+FRAC-1:FRAC];
               if (fec_r != '0) begin
                  st <= ST_MFEC; kick <= 1'b1;
               end else begin
                  st <= ST_PREP;
               end
            end
            ST_MFEC: if (mul_done) begin
               raw <= mul_prod[QW+FRAC-1:FRAC];
               st  <= ST_PREP;
            end
            ST_PREP: begin
               kick <= 1'b1;
               if (raw[FRAC-1:0] == '0) begin
                  enum_r <= lane_scale;
                  st     <= ST_DFR;
               end else begin
                  st <= ST_MEN;
               end
            end
            ST_MEN: if (mul_done) begin
               enum_r <= mul_prod[FRAC+EN_W-1:FRAC];
               st     <= ST_DFR;
               kick   <= 1'b1;
            end
            ST_DFR: if (div_done) begin
               tss  <= {raw[QW-1:FRAC], {FRAC{1'b0}}} + div_quo;
               st   <= ST_MLN;
               kick <= 1'b1;
            end
            ST_MLN: if (mul_done) begin
               tss <= mul_prod[QW-1:0];
               st  <= ST_FIN;
            end
            ST_FIN: begin
               x_int  <= tss[QW-1:FRAC];
               y_frac <= {1'b0, tss[FRAC-1 -: 8]} + Y_W'(|tss[FRAC-9:0]);
               err    <= 1'b0;
               done   <= 1'b1;
               busy   <= 1'b0;
               st     <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/slot_pace_chk.sv
module slot_pace_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        start,
   input logic        busy,
   input logic        done,
   input logic        err,
   input logic [31:0] x_int,
   input logic [8:0]  y_frac
);
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(x_int) && $stable(y_frac) && $stable(err)));

   assert_err_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> (x_int == 32'd0 && y_frac == 9'd0));

   assert_yrange_R6: assert property (@(posedge clk) disable iff (!rst_n)
      y_frac <= 9'd256);

   assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || done));
endmodule

bind slot_pace_calc slot_pace_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .busy   (busy),
   .done   (done),
   .err    (err),
   .x_int  (x_int),
   .y_frac (y_frac)
);

// File: tb/sim_slot_pace_calc.sv
module sim_slot_pace_calc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [19:0] pclk_khz = '0;
   logic [7:0]  bpp = '0;
   logic        comp_en = 1'b0;
   logic [7:0]  comp_bpp = '0;
   logic [14:0] pbn = '0;
   logic [19:0] lclk = '0;
   logic [2:0]  lanes = '0;
   logic [63:0] dsc_fp = '0;
   logic [63:0] fec_fp = '0;
   logic        busy, done, err;
   logic [31:0] x_int;
   logic [8:0]  y_frac;

   int nchk = 0;
   int nerr = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   slot_pace_calc u0 (.*);

   localparam int NV = 6;
   localparam logic [19:0] T_PCLK [NV] = '{20'd148500, 20'd594000, 20'd297000, 20'd148500, 20'd25175, 20'd1000};
   localparam logic [7:0]  T_BPP  [NV] = '{8'd24, 8'd30, 8'd24, 8'd24, 8'd18, 8'd8};
   localparam logic        T_CEN  [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
   localparam logic [7:0]  T_CBPP [NV] = '{8'd12, 8'd0, 8'd8, 8'd0, 8'd0, 8'd0};
   localparam logic [14:0] T_PBN  [NV] = '{15'd1000, 15'd3000, 15'd600, 15'd700, 15'd100, 15'd2};
   localparam logic [19:0] T_LCLK [NV] = '{20'd270000, 20'd810000, 20'd540000, 20'd162000, 20'd270000, 20'd1000};
   localparam logic [2:0]  T_LN   [NV] = '{3'd4, 3'd4, 3'd2, 3'd1, 3'd2, 3'd1};
   localparam logic [63:0] T_DSC  [NV] = '{64'd0, 64'd0, 64'h1_0A3D_70A4, 64'd0, 64'h1_2000_0000, 64'd0};
   localparam logic [63:0] T_FEC  [NV] = '{64'd0, 64'd0, 64'd0, 64'h1_0100_0000, 64'h1_0100_0000, 64'd0};

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic void ref_calc(
      input logic [19:0] p, input logic [7:0] b, input logic ce, input logic [7:0] cb,
      input logic [14:0] pb, input logic [19:0] lc, input logic [2:0] ln,
      input logic [63:0] ds, input logic [63:0] fc,
      output logic [31:0] xo, output logic [8:0] yo, output logic eo);
      logic [127:0] den, mn, mx, raw, ten, tss, be, sc;
      logic [127:0] m64;
      m64 = {64'd0, {64{1'b1}}};
      if (lc == 0 || ln == 0) begin
         xo = 0; yo = 0; eo = 1'b1;
         return;
      end
      eo  = 1'b0;
      be  = ce ? 128'(cb) : 128'(b);
      den = 128'(lc) * 128'(ln);
      mn  = ((128'(p) * be * 128'd8) << 32) / den;
      mx  = ((128'(pb) * 128'd54000) << 32) / den;
      raw = (mn + mx) >> 1;
      if (ds != 0) raw = ((raw * 128'(ds)) >> 32) & m64;
      if (fc != 0) raw = ((raw * 128'(fc)) >> 32) & m64;
      sc  = 128'(ln) * 128'd256;
      if (raw[31:0] != 0) ten = (128'(raw[31:0]) * sc) >> 32;
      else ten = sc;
      tss = (((raw >> 32) << 32) + ((ten << 32) / sc)) & m64;
      tss = (tss * 128'(ln)) & m64;
      xo  = tss[63:32];
      yo  = 9'(tss[31:24]) + 9'(tss[23:0] != 0);
   endfunction

   task automatic drive(input int i);
      pclk_khz = T_PCLK[i]; bpp = T_BPP[i]; comp_en = T_CEN[i]; comp_bpp = T_CBPP[i];
      pbn = T_PBN[i]; lclk = T_LCLK[i]; lanes = T_LN[i]; dsc_fp = T_DSC[i]; fec_fp = T_FEC[i];
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      int n = 0;
      while (!done && n < 5000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic run_vec(input int i);
      logic [31:0] ex; logic [8:0] ey; logic ee;
      ref_calc(T_PCLK[i], T_BPP[i], T_CEN[i], T_CBPP[i], T_PBN[i], T_LCLK[i], T_LN[i],
               T_DSC[i], T_FEC[i], ex, ey, ee);
      @(negedge clk);
      drive(i);
      pulse_start();
      check("R8 busy during calculation", 64'(busy), 64'd1);
      wait_done();
      check("R2 R3 R4 R5 R6 x_int", 64'(x_int), 64'(ex));
      check("R6 y_frac", 64'(y_frac), 64'(ey));
      check("R7 err clear", 64'(err), 64'(ee));
      @(negedge clk);
      check("R8 done one cycle", 64'(done), 64'd0);
   endtask

   initial begin
      logic [31:0] hx; logic [8:0] hy; logic he;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 busy", 64'(busy), 64'd0);
      check("R1 done", 64'(done), 64'd0);
      check("R1 err", 64'(err), 64'd0);
      check("R1 x_int", 64'(x_int), 64'd0);
      check("R1 y_frac", 64'(y_frac), 64'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) run_vec(i);

      // R5 exact-integer target: bounds 64 and 108, mean 86, carried to 87
      drive(5);
      pulse_start();
      wait_done();
      check("R5 exact x_int", 64'(x_int), 64'd87);
      check("R5 exact y_frac", 64'(y_frac), 64'd0);

      // R8 outputs held after done
      hx = x_int; hy = y_frac;
      repeat (6) @(negedge clk);
      check("R8 hold x_int", 64'(x_int), 64'(hx));
      check("R8 hold y_frac", 64'(y_frac), 64'(hy));

      // R7 zero link rate
      drive(0); lclk = '0;
      pulse_start();
      check("R7 done after zero divisor", 64'(done), 64'd1);
      check("R7 err set", 64'(err), 64'd1);
      check("R7 x zero", 64'(x_int), 64'd0);
      check("R7 y zero", 64'(y_frac), 64'd0);

      // R7 zero lanes
      @(negedge clk);
      drive(1); lanes = '0;
      pulse_start();
      wait_done();
      check("R7 lanes zero err", 64'(err), 64'd1);
      check("R7 lanes zero x", 64'(x_int), 64'd0);

      // R9 start while busy with other inputs is ignored
      @(negedge clk);
      ref_calc(T_PCLK[2], T_BPP[2], T_CEN[2], T_CBPP[2], T_PBN[2], T_LCLK[2], T_LN[2],
               T_DSC[2], T_FEC[2], hx, hy, he);
      drive(2);
      pulse_start();
      repeat (20) @(negedge clk);
      drive(4);
      pulse_start();
      drive(1);
      wait_done();
      check("R9 x_int from first start", 64'(x_int), 64'(hx));
      check("R9 y_frac from first start", 64'(y_frac), 64'(hy));
      check("R9 err", 64'(err), 64'(he));
      @(negedge clk);
      check("R9 no second calculation", 64'(busy), 64'd0);

      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         nchk++;
         nerr++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule